// File: doc/BRIEF.md
# Configurable Address Translation Cache

The block holds a small, fully associative set of logical-to-physical page translations behind a 32-bit control register. A requester presents a logical address and a write flag. If the page is cached, the block reports a hit in the same cycle and returns the physical address, the attribute bits and the entry's modified flag. On a miss it raises a search request toward an external table walker. The walker answers through a fill port, and the answer is installed in a round-robin slot.

Software sets the behaviour through the control register. It can choose 4 KB or 8 KB pages, halve the number of usable entries, or freeze the contents so that misses no longer allocate. It can also switch translation off, and the addresses then pass through untranslated. A separate flush pulse invalidates every entry. Neither a reset nor a control write disturbs the cached entries, so software flushes before it turns translation on. A single transparent-match input from outside comparators forces pass-through for the current access.

Control register layout: bit 0 enables translation. Bit 1 selects 8 KB pages. Bit 2 freezes allocation. Bit 3 selects half capacity. Bits 5:4 hold the default cache mode. Bits 7:6 hold the default user bits. Bit 8 holds the default write protect. Bits 31:9 always read zero.

Top module: `xlat_cache`

## Requirements
- R1: With the enable bit (bit 0) clear, lk_paddr equals lk_addr, lk_hit is 0, and a lookup raises no walk request.
- R2: With translation disabled and tt_match low, lk_cmode, lk_ubits and lk_wprot show the default fields (bits 5:4, 7:6 and 8). While tt_match is high, the address passes through with lk_hit 0, those attributes are 0, and no walk request is raised, even when translation is enabled.
- R3: With bit 1 at 0, the low 12 address bits pass through and bits 31:12 form the tag. With bit 1 at 1, the low 13 bits pass through and bits 31:13 form the tag. A hit therefore returns physical bit 12 from the logical address in 8 KB mode.
- R4: An enabled lookup that misses sets walk_req on the next clock, with walk_addr holding the lookup address. Both hold until fill_valid is seen, and walk_req is low on the clock after that.
- R5: When allocation is permitted, a fill writes the returned frame and attributes into the round-robin slot. A later lookup of that page hits in the same cycle it is presented, with the installed values.
- R6: With the freeze bit (bit 2) set, hits are still serviced and a miss still raises a walk request, but the fill writes no entry: the page misses again afterwards.
- R7: A write lookup that hits sets the entry's modified flag (lk_dirty), in frozen mode too, and the entry stays valid. An entry filled for a write miss starts with lk_dirty 1.
- R8: With the half bit (bit 3) at 0, all 64 entries match and allocate, and the replacement pointer wraps after slot 63. With it at 1, only slots 0 to 31 match and allocate, and the pointer wraps after slot 31.
- R9: A flush pulse invalidates every entry whether or not translation is enabled. A reset and control writes leave the entries intact.
- R10: Reset clears the control register. Bits 31:9 read back zero whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control and sequencing state |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read value |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address of the lookup |
| lk_write | input | 1 | Lookup is a write access |
| tt_match | input | 1 | External transparent-match indication |
| lk_hit | output | 1 | Cached translation found |
| lk_paddr | output | 32 | Physical (or passed-through) address |
| lk_cmode | output | 2 | Cache mode attribute |
| lk_ubits | output | 2 | User attribute bits |
| lk_wprot | output | 1 | Write protect attribute |
| lk_dirty | output | 1 | Modified flag of the hit entry |
| walk_req | output | 1 | Table search request |
| walk_addr | output | 32 | Logical address to search |
| fill_valid | input | 1 | Walk result available |
| fill_ppn | input | 20 | Physical frame bits 31:12 |
| fill_cmode | input | 2 | Cache mode of the result |
| fill_ubits | input | 2 | User bits of the result |
| fill_wprot | input | 1 | Write protect of the result |

## Verification
Lookups run against a reference array that models tag masking, lowest-index priority and the round-robin pointer. Each access is either a hit, compared on address, attributes and modified flag, or a miss whose walk handshake is checked. Sixty-four distinct pages followed by fresh misses show where the pointer wraps and which page is evicted, and a switch to half capacity shows that upper slots disappear and return without being lost. A 4 KB/8 KB change tells apart pages that differ only in bit 12. A frozen run separates hit servicing from allocation. A mid-run reset and bare control writes, with no flush between them, show that entries survive.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int CFG_BITS = 9;

    typedef struct packed {
        logic       dwp;
        logic [1:0] dub;
        logic [1:0] dcm;
        logic       half;
        logic       frz;
        logic       pg8k;
        logic       en;
    } cfg_t;

    typedef struct packed {
        logic [1:0] cm;
        logic [1:0] ub;
        logic       wp;
    } attr_t;
endpackage

// File: rtl/xlat_cfg.sv
module xlat_cfg
    import xlat_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output logic [DW-1:0] rdata
);
    cfg_t cfg_d, cfg_q;
    logic unused_hi;

    assign unused_hi = ^wdata[DW-1:CFG_BITS];

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = cfg_t'(wdata[CFG_BITS-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign rdata = {{(DW-CFG_BITS){1'b0}}, cfg_q};

    // R10: the register only changes on a write strobe
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));
endmodule

// File: rtl/xlat_walk.sv
module xlat_walk #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic          write,
    input  logic          fill_valid,
    output logic          req,
    output logic [AW-1:0] req_addr,
    output logic          req_write
);
    typedef struct packed {
        logic          busy;
        logic [AW-1:0] a;
        logic          w;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (fill_valid) st_d.busy = 1'b0;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.a    = addr;
            st_d.w    = write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req       = st_q.busy;
    assign req_addr  = st_q.a;
    assign req_write = st_q.w;

    // R4: request and address held until the fill arrives
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req && !fill_valid |=> req && $stable(req_addr));
    // R4: request drops after the fill handshake
    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req && fill_valid |=> !req);
endmodule

// File: rtl/xlat_array.sv
module xlat_array
    import xlat_pkg::*;
#(
    parameter int AW = 32,
    parameter int PL = 12,
    parameter int N  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pg8k,
    input  logic             half,
    input  logic             frz,
    input  logic             flush,
    input  logic             lk_on,
    input  logic [AW-1:0]    lk_addr,
    input  logic             lk_write,
    input  logic             fill_fire,
    input  logic [AW-PL-1:0] fill_tag,
    input  logic [AW-PL-1:0] fill_ppn,
    input  attr_t            fill_attr,
    input  logic             fill_dirty,
    output logic             hit,
    output logic [AW-1:0]    paddr,
    output attr_t            attr,
    output logic             dirty
);
    localparam int TAG_W = AW - PL;
    localparam int IDX_W = $clog2(N);
    localparam int HALF  = N / 2;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] ppn;
        attr_t            at;
        logic             dirty;
    } ent_t;

    ent_t             ent_d [N];
    ent_t             ent_q [N];
    logic [N-1:0]     vld_d, vld_q;
    logic [IDX_W-1:0] ptr_d, ptr_q;
    logic [TAG_W-1:0] tmask, lk_tag;
    logic [N-1:0]     mvec;
    logic [IDX_W-1:0] hit_idx, fidx, last;

    assign tmask  = pg8k ? ~TAG_W'(1) : '1;
    assign lk_tag = lk_addr[AW-1:PL];

    for (genvar i = 0; i < N; i++) begin : g_match
        assign mvec[i] = vld_q[i] && (((ent_q[i].tag ^ lk_tag) & tmask) == '0)
                         && (!half || (i < HALF));
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mvec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign paddr = {(ent_q[hit_idx].ppn & tmask) | (lk_tag & ~tmask), lk_addr[PL-1:0]};
    assign attr  = ent_q[hit_idx].at;
    assign dirty = ent_q[hit_idx].dirty;

    assign fidx = (half && (ptr_q >= IDX_W'(HALF))) ? '0 : ptr_q;
    assign last = half ? IDX_W'(HALF - 1) : IDX_W'(N - 1);

    always_comb begin
        ent_d = ent_q;
        vld_d = vld_q;
        ptr_d = ptr_q;
        if (lk_on && hit && lk_write) ent_d[hit_idx].dirty = 1'b1;
        if (fill_fire && !frz) begin
            ent_d[fidx].tag   = fill_tag & tmask;
            ent_d[fidx].ppn   = fill_ppn;
            ent_d[fidx].at    = fill_attr;
            ent_d[fidx].dirty = fill_dirty;
            vld_d[fidx]       = 1'b1;
            ptr_d             = (fidx == last) ? '0 : fidx + 1'b1;
        end
        if (flush) begin
            vld_d = '0;
            ptr_d = '0;
        end
    end

    // entries deliberately survive reset
    always_ff @(posedge clk) begin
        ent_q <= ent_d;
        vld_q <= vld_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // R9: flush empties the array
    p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> vld_q == '0);
    // R6: a frozen fill leaves the valid set untouched
    p_freeze_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_fire && frz && !flush |=> $stable(vld_q));
    // R5: a permitted fill makes its slot valid
    p_fill_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_fire && !frz && !flush |=> vld_q[$past(fidx)]);
    // R8: in half mode no hit comes from the upper slots
    p_half_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit && half |-> hit_idx < IDX_W'(HALF));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int AW = 32,
    parameter int PL = 12,
    parameter int N  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [AW-1:0]    lk_addr,
    input  logic             lk_write,
    input  logic             tt_match,
    output logic             lk_hit,
    output logic [AW-1:0]    lk_paddr,
    output logic [1:0]       lk_cmode,
    output logic [1:0]       lk_ubits,
    output logic             lk_wprot,
    output logic             lk_dirty,
    output logic             walk_req,
    output logic [AW-1:0]    walk_addr,
    input  logic             fill_valid,
    input  logic [AW-PL-1:0] fill_ppn,
    input  logic [1:0]       fill_cmode,
    input  logic [1:0]       fill_ubits,
    input  logic             fill_wprot
);
    cfg_t             cfg;
    logic             bypass, lk_on, a_hit, a_dirty, fill_fire, walk_w;
    logic [AW-1:0]    a_paddr;
    attr_t            a_attr, fill_attr, out_attr;

    xlat_cfg #(.DW(32)) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    assign bypass    = !cfg.en || tt_match;
    assign lk_on     = lk_valid && !bypass;
    assign fill_fire = fill_valid && walk_req;
    assign fill_attr = '{cm: fill_cmode, ub: fill_ubits, wp: fill_wprot};

    xlat_walk #(.AW(AW)) i_walk (
        .clk(clk), .rst_n(rst_n), .start(lk_on && !a_hit), .addr(lk_addr),
        .write(lk_write), .fill_valid(fill_valid), .req(walk_req),
        .req_addr(walk_addr), .req_write(walk_w)
    );

    xlat_array #(.AW(AW), .PL(PL), .N(N)) i_array (
        .clk(clk), .rst_n(rst_n), .pg8k(cfg.pg8k), .half(cfg.half), .frz(cfg.frz),
        .flush(flush), .lk_on(lk_on), .lk_addr(lk_addr), .lk_write(lk_write),
        .fill_fire(fill_fire), .fill_tag(walk_addr[AW-1:PL]), .fill_ppn(fill_ppn),
        .fill_attr(fill_attr), .fill_dirty(walk_w), .hit(a_hit), .paddr(a_paddr),
        .attr(a_attr), .dirty(a_dirty)
    );

    always_comb begin
        lk_hit   = lk_on && a_hit;
        lk_paddr = lk_hit ? a_paddr : lk_addr;
        lk_dirty = lk_hit && a_dirty;
        if (lk_hit)                    out_attr = a_attr;
        else if (!cfg.en && !tt_match) out_attr = '{cm: cfg.dcm, ub: cfg.dub, wp: cfg.dwp};
        else                           out_attr = '0;
    end

    assign lk_cmode = out_attr.cm;
    assign lk_ubits = out_attr.ub;
    assign lk_wprot = out_attr.wp;

    // R1: disabled lookups never start a search
    p_off_nowalk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !cfg.en && !walk_req |=> !walk_req);
    // R2: transparent matches never start a search
    p_tt_nowalk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && tt_match && !walk_req |=> !walk_req);
endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0, flush = 0, lk_valid = 0, lk_write = 0, tt_match = 0;
    logic [31:0] cfg_wdata = 0, lk_addr = 0;
    logic [31:0] cfg_rdata, lk_paddr, walk_addr;
    logic        lk_hit, lk_wprot, lk_dirty, walk_req;
    logic [1:0]  lk_cmode, lk_ubits;
    logic        fill_valid = 0, fill_wprot = 0;
    logic [19:0] fill_ppn = 0;
    logic [1:0]  fill_cmode = 0, fill_ubits = 0;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    bit          m_v [64];
    bit          m_d [64];
    logic [19:0] m_tag [64];
    logic [19:0] m_ppn [64];
    logic [4:0]  m_at [64];
    int          m_ptr = 0;
    bit c_en = 0, c_pg = 0, c_frz = 0, c_half = 0;

    // {logical address, write, physical frame address}
    localparam logic [64:0] VEC [8] = '{
        {32'h0001_0abc, 1'b0, 32'h00a0_0000},
        {32'h0001_0ff0, 1'b0, 32'h0000_0000},
        {32'h0002_0004, 1'b1, 32'h00b0_0000},
        {32'h0002_0008, 1'b0, 32'h0000_0000},
        {32'h0001_0000, 1'b1, 32'h0000_0000},
        {32'h0001_0010, 1'b0, 32'h0000_0000},
        {32'h0003_1fff, 1'b0, 32'h00c0_5000},
        {32'h0003_1000, 1'b0, 32'h0000_0000}
    };

    xlat_cache i_xlat_cache (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .flush(flush), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_write(lk_write), .tt_match(tt_match), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .lk_cmode(lk_cmode), .lk_ubits(lk_ubits), .lk_wprot(lk_wprot),
        .lk_dirty(lk_dirty), .walk_req(walk_req), .walk_addr(walk_addr),
        .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_cmode(fill_cmode),
        .fill_ubits(fill_ubits), .fill_wprot(fill_wprot)
    );

    always #2 clk = ~clk;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [31:0] v);
        cfg_we = 1; cfg_wdata = v;
        tick();
        cfg_we = 0;
        c_en = v[0]; c_pg = v[1]; c_frz = v[2]; c_half = v[3];
    endtask

    task automatic do_flush();
        flush = 1;
        tick();
        flush = 0;
        for (int i = 0; i < 64; i++) m_v[i] = 0;
        m_ptr = 0;
    endtask

    function automatic logic [4:0] attr_of(input logic [31:0] a);
        return a[16:12] ^ 5'h15;
    endfunction

    // one enabled lookup, checked against the reference array; a miss is filled
    task automatic access(input logic [31:0] a, input bit w, input logic [31:0] ph,
                          input string rq);
        int lim = c_half ? 32 : 64;
        int hi = -1;
        int idx;
        logic [19:0] msk = c_pg ? 20'hffffe : 20'hfffff;
        for (int i = 0; i < lim; i++)
            if (hi < 0 && m_v[i] && (((m_tag[i] ^ a[31:12]) & msk) == 0)) hi = i;
        lk_valid = 1; lk_addr = a; lk_write = w;
        #1;
        if (hi >= 0) begin
            chk({rq, " hit"}, {31'b0, lk_hit}, 1);
            chk({rq, " paddr"}, lk_paddr, {(m_ppn[hi] & msk) | (a[31:12] & ~msk), a[11:0]});
            chk({rq, " attr"}, {27'b0, lk_cmode, lk_ubits, lk_wprot}, {27'b0, m_at[hi]});
            chk({rq, " R7 dirty"}, {31'b0, lk_dirty}, {31'b0, m_d[hi]});
        end else begin
            chk({rq, " miss"}, {31'b0, lk_hit}, 0);
        end
        tick();
        lk_valid = 0; lk_write = 0;
        if (hi >= 0) begin
            if (w) m_d[hi] = 1;
            chk({rq, " R4 no walk on hit"}, {31'b0, walk_req}, 0);
        end else begin
            chk({rq, " R4 walk_req"}, {31'b0, walk_req}, 1);
            chk({rq, " R4 walk_addr"}, walk_addr, a);
            tick();
            chk({rq, " R4 walk held"}, {31'b0, walk_req}, 1);
            fill_valid = 1; fill_ppn = ph[31:12];
            {fill_cmode, fill_ubits, fill_wprot} = attr_of(a);
            tick();
            fill_valid = 0;
            chk({rq, " R4 walk drop"}, {31'b0, walk_req}, 0);
            if (!c_frz) begin
                idx = (c_half && m_ptr >= 32) ? 0 : m_ptr;
                m_v[idx] = 1; m_tag[idx] = a[31:12] & msk; m_ppn[idx] = ph[31:12];
                m_d[idx] = w; m_at[idx] = attr_of(a);
                m_ptr = (idx == lim - 1) ? 0 : idx + 1;
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10 reset value", cfg_rdata, 0);
        chk("R4 idle after reset", {31'b0, walk_req}, 0);

        wr_cfg(32'hffff_fff0);
        chk("R10 reserved bits", cfg_rdata, 32'h0000_01f0);
        c_en = 0; c_pg = 0; c_frz = 0; c_half = 0;

        // disabled: defaults cm=3 ub=3 wp=1 from the write above
        lk_valid = 1; lk_addr = 32'h1234_5678; #1;
        chk("R1 passthrough", lk_paddr, 32'h1234_5678);
        chk("R1 no hit", {31'b0, lk_hit}, 0);
        chk("R2 default attr", {27'b0, lk_cmode, lk_ubits, lk_wprot}, 32'h1f);
        tick();
        chk("R1 no walk", {31'b0, walk_req}, 0);
        wr_cfg(32'h0000_0090);  // cm=1 ub=2 wp=0
        lk_valid = 1; #1;
        chk("R2 default attr fields", {27'b0, lk_cmode, lk_ubits, lk_wprot}, 32'h0c);
        tt_match = 1; #1;
        chk("R2 tt attr zero", {27'b0, lk_cmode, lk_ubits, lk_wprot}, 0);
        tick();
        lk_valid = 0; tt_match = 0;

        do_flush();  // R9 flush while disabled
        wr_cfg(32'h1);
        for (int k = 0; k < 8; k++)
            access(VEC[k][64:33], VEC[k][32], VEC[k][31:0], "R5 table");

        // R2 transparent match overrides an enabled hit
        lk_valid = 1; lk_addr = 32'h0001_0abc; tt_match = 1; #1;
        chk("R2 tt passthrough", lk_paddr, 32'h0001_0abc);
        chk("R2 tt no hit", {31'b0, lk_hit}, 0);
        tick();
        chk("R2 tt no walk", {31'b0, walk_req}, 0);
        lk_valid = 0; tt_match = 0;

        // R3 page size
        wr_cfg(32'h3);
        access(32'h0004_2000, 0, 32'h0008_0000, "R3 8k fill");
        access(32'h0004_3abc, 0, 0, "R3 8k bit12 passes");
        wr_cfg(32'h1);
        access(32'h0004_3abc, 0, 32'h0009_0000, "R3 4k distinct page");
        access(32'h0004_3abc, 0, 0, "R3 4k hit");

        // R9 reset keeps entries
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        c_en = 0; c_pg = 0; c_frz = 0; c_half = 0; m_ptr = 0;
        chk("R10 cleared by reset", cfg_rdata, 0);
        wr_cfg(32'h1);
        access(32'h0001_0abc, 0, 0, "R9 survives reset");
        wr_cfg(32'h0000_0031);
        access(32'h0002_0004, 0, 0, "R9 survives cfg write");

        // R6 freeze
        wr_cfg(32'h5);
        access(32'h0005_0000, 0, 32'h00d0_0000, "R6 frozen miss");
        access(32'h0005_0000, 0, 32'h00d0_0000, "R6 still misses");
        access(32'h0003_1000, 1, 0, "R7 frozen write hit");
        access(32'h0003_1004, 0, 0, "R7 modified stays valid");

        // R8 round robin over 64 then half capacity
        do_flush();
        wr_cfg(32'h1);
        for (int p = 0; p < 64; p++)
            access(32'((p + 256) << 12), 0, 32'((p + 512) << 12), "R8 fill 64");
        access(32'h0010_0010, 0, 0, "R8 all 64 kept");
        access(32'h0018_0000, 0, 32'h0030_0000, "R8 wrap evicts slot 0");
        access(32'h0010_0010, 0, 32'h0020_0000, "R8 evicted page misses");
        access(32'h0010_2000, 0, 0, "R8 slot 2 still hits");
        wr_cfg(32'h9);
        access(32'h0013_0000, 0, 32'h0023_0000, "R8 upper slot hidden");
        for (int p = 0; p < 36; p++)
            access(32'((p + 1024) << 12), 0, 32'((p + 2048) << 12), "R8 half wrap");
        access(32'h0040_0000, 0, 32'h0080_0000, "R8 half evicted");
        wr_cfg(32'h1);
        access(32'h0013_8000, 0, 0, "R8 upper slot back");
        access(32'h0012_f000, 0, 0, "R8 upper slot back 2");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule